// File: doc/BRIEF.md
# Precomputation-Gated Content-Addressable Memory

This block is a small associative store of `WORDS` entries, each `WIDTH` bits wide (8 entries of 14 bits by default). Next to every stored word it keeps a short signature, computed from the word when the word is written. A lookup works in two steps. The first step derives the signature of the search key and compares it with the signature of every live entry, all in one step. The second step runs the full-width data compare only in the entries whose signature agrees. Entries whose signature differs never reach the wide comparator.

The signature function is chosen when the block is elaborated. One choice counts the 1 bits of the word. The other cuts the word into equal slices and XORs the slices together, which spreads the signatures more evenly over typical contents. A write stores a word at an address and marks that entry live. An invalidate input marks an entry empty.

Each lookup returns one clock later. It gives a hit flag, the lowest matching address, and the number of wide compares that were enabled. That number is a stand-in for the energy the lookup used. A two-state result sequencer produces the result strobe. In state `RES_IDLE` no result is shown. In state `RES_SHOW` a result is shown. A search cycle moves the sequencer from either state to `RES_SHOW`. A cycle with no search moves it from either state to `RES_IDLE`.

Top module: `pcam_top`

## Requirements
- R1: With the count extractor, the signature of a word is its number of 1 bits. The signature is SW = ceil(log2(WIDTH+2)) bits wide, which is 4 bits for 14-bit words.
- R2: With the slice extractor, the word is zero-extended on the high side to a multiple of SW bits. It is then split into SW-bit slices, starting from bit 0, and the signature is the XOR of all the slices.
- R3: A write (`wr_en`) stores `wr_data` and its signature at `wr_addr` and makes that entry live. An invalidate (`inv_en`) makes the entry at `inv_addr` empty. When both name the same entry in the same cycle, the entry ends up empty.
- R4: After reset every entry is empty and `res_valid` is 0. A lookup of any key, including all zeros, then misses with a compare count of 0.
- R5: An empty entry never reports a hit and never adds to the compare count, whatever data it last held.
- R6: `res_cmp_count` equals the number of live entries whose signature equals the key's signature. It is never larger than the number of live entries.
- R7: `res_hit` is 1 exactly when some live entry holds data equal to the key. `res_addr` is then the lowest such address.
- R8: `res_valid` is 1 in the cycle after each cycle with `srch_en` high, and 0 after each cycle without it. Back-to-back searches give back-to-back results. A lookup made in the same cycle as a write sees the contents from before that write.
- R9: On a miss, `res_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Store a word this cycle |
| wr_addr | input | AW = ceil(log2(WORDS)) | Entry to store into |
| wr_data | input | WIDTH | Word to store |
| inv_en | input | 1 | Mark an entry empty this cycle |
| inv_addr | input | AW | Entry to mark empty |
| srch_en | input | 1 | Start a lookup this cycle |
| srch_key | input | WIDTH | Key to look up |
| res_valid | output | 1 | A lookup result is shown |
| res_hit | output | 1 | The key was found |
| res_addr | output | AW | Lowest matching address, 0 on a miss |
| res_cmp_count | output | ceil(log2(WORDS+1)) | Wide compares enabled by the lookup |

## Verification
The bench drives two copies of the block side by side, one with each extractor, and checks the results against a scoreboard model. It looks up keys that share a signature with a stored word but differ from it. A design that skipped the signature gate would overcount compares there, and one that used the signature alone as a match would report false hits. It stores duplicate words, so a wrong priority shows up as a higher address. It also looks up data left in entries that have been invalidated or never written, and makes a write and an invalidate of the same entry in the same cycle. A design that let stale entries through would hit or count where it must not. Last, it makes a lookup in the same cycle as a write, so a design that sees the new data one cycle early is caught.

// File: rtl/pcam_pkg.sv
`timescale 1ns/1ps
package pcam_pkg;
    typedef enum logic {
        EXT_ONES = 1'b0,
        EXT_BXOR = 1'b1
    } ext_kind_e;

    typedef enum logic {
        RES_IDLE = 1'b0,
        RES_SHOW = 1'b1
    } res_state_e;
endpackage

// File: rtl/pcam_param_extract.sv
`timescale 1ns/1ps
module pcam_param_extract #(
    parameter int                  WIDTH = 14,
    parameter pcam_pkg::ext_kind_e KIND  = pcam_pkg::EXT_ONES,
    parameter int                  SW    = $clog2(WIDTH + 2)
) (
    input  logic [WIDTH-1:0] word,
    output logic [SW-1:0]    sig
);
    generate
        if (KIND == pcam_pkg::EXT_ONES) begin : g_ones
            // R1: population count of the word
            always_comb begin
                sig = '0;
                for (int i = 0; i < WIDTH; i++) begin
                    sig = sig + SW'(word[i]);
                end
            end
        end else begin : g_bxor
            // R2: XOR of SW-bit slices, high side zero-extended
            localparam int NSLICE = (WIDTH + SW - 1) / SW;
            logic [NSLICE*SW-1:0] padded;
            always_comb begin
                padded            = '0;
                padded[WIDTH-1:0] = word;
                sig               = '0;
                for (int s = 0; s < NSLICE; s++) begin
                    sig = sig ^ padded[s*SW +: SW];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pcam_entry.sv
`timescale 1ns/1ps
module pcam_entry #(
    parameter int WIDTH = 14,
    parameter int SW    = 4,
    parameter int AW    = 3,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [SW-1:0]    wr_sig,
    input  logic             inv_en,
    input  logic [AW-1:0]    inv_addr,
    input  logic [WIDTH-1:0] key,
    input  logic [SW-1:0]    key_sig,
    output logic             live,
    output logic             sig_eq,
    output logic             data_eq
);
    logic [WIDTH-1:0] data_q;
    logic [SW-1:0]    sig_q;
    logic             empty_q;
    logic             wr_sel;
    logic             inv_sel;

    assign wr_sel  = wr_en  && (wr_addr  == AW'(IDX));
    assign inv_sel = inv_en && (inv_addr == AW'(IDX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            sig_q   <= '0;
            empty_q <= 1'b1;
        end else begin
            if (wr_sel) begin
                data_q <= wr_data;
                sig_q  <= wr_sig;
            end
            if (inv_sel) begin
                empty_q <= 1'b1;
            end else if (wr_sel) begin
                empty_q <= 1'b0;
            end
        end
    end

    assign live = !empty_q;

    // First stage: signature compare. The wide compare runs only behind it.
    always_comb begin
        sig_eq  = live && (sig_q == key_sig);
        data_eq = 1'b0;
        if (sig_eq) begin
            data_eq = (data_q == key);
        end
    end

    p_write_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !inv_sel) |=> live);
    p_inv_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inv_sel |=> !live);
endmodule

// File: rtl/pcam_resolve.sv
`timescale 1ns/1ps
module pcam_resolve #(
    parameter int WORDS = 8,
    parameter int AW    = 3,
    parameter int CW    = 4
) (
    input  logic [WORDS-1:0] sig_eq,
    input  logic [WORDS-1:0] data_eq,
    output logic             any_hit,
    output logic [AW-1:0]    hit_addr,
    output logic [CW-1:0]    cmp_count
);
    always_comb begin
        any_hit  = 1'b0;
        hit_addr = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (data_eq[i]) begin
                any_hit  = 1'b1;
                hit_addr = AW'(i);
            end
        end
    end

    always_comb begin
        cmp_count = '0;
        for (int i = 0; i < WORDS; i++) begin
            cmp_count = cmp_count + CW'(sig_eq[i]);
        end
    end
endmodule

// File: rtl/pcam_top.sv
`timescale 1ns/1ps
module pcam_top #(
    parameter int                  WORDS   = 8,
    parameter int                  WIDTH   = 14,
    parameter pcam_pkg::ext_kind_e EXTRACT = pcam_pkg::EXT_ONES,
    parameter int                  AW      = (WORDS > 1) ? $clog2(WORDS) : 1,
    parameter int                  CW      = $clog2(WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             inv_en,
    input  logic [AW-1:0]    inv_addr,
    input  logic             srch_en,
    input  logic [WIDTH-1:0] srch_key,
    output logic             res_valid,
    output logic             res_hit,
    output logic [AW-1:0]    res_addr,
    output logic [CW-1:0]    res_cmp_count
);
    import pcam_pkg::*;

    localparam int SW = $clog2(WIDTH + 2);

    logic [SW-1:0]    wr_sig;
    logic [SW-1:0]    key_sig;
    logic [WORDS-1:0] live;
    logic [WORDS-1:0] sig_eq;
    logic [WORDS-1:0] data_eq;
    logic             any_hit;
    logic [AW-1:0]    hit_addr;
    logic [CW-1:0]    cmp_count;
    res_state_e       state_q;
    res_state_e       state_nx;

    pcam_param_extract #(.WIDTH(WIDTH), .KIND(EXTRACT), .SW(SW)) u_wr_sig (
        .word (wr_data),
        .sig  (wr_sig)
    );

    pcam_param_extract #(.WIDTH(WIDTH), .KIND(EXTRACT), .SW(SW)) u_key_sig (
        .word (srch_key),
        .sig  (key_sig)
    );

    generate
        for (genvar g = 0; g < WORDS; g++) begin : g_entry
            pcam_entry #(.WIDTH(WIDTH), .SW(SW), .AW(AW), .IDX(g)) u_entry (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_en),
                .wr_addr  (wr_addr),
                .wr_data  (wr_data),
                .wr_sig   (wr_sig),
                .inv_en   (inv_en),
                .inv_addr (inv_addr),
                .key      (srch_key),
                .key_sig  (key_sig),
                .live     (live[g]),
                .sig_eq   (sig_eq[g]),
                .data_eq  (data_eq[g])
            );
        end
    endgenerate

    pcam_resolve #(.WORDS(WORDS), .AW(AW), .CW(CW)) u_resolve (
        .sig_eq    (sig_eq),
        .data_eq   (data_eq),
        .any_hit   (any_hit),
        .hit_addr  (hit_addr),
        .cmp_count (cmp_count)
    );

    // Result sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RES_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            RES_IDLE: state_nx = srch_en ? RES_SHOW : RES_IDLE;
            RES_SHOW: state_nx = srch_en ? RES_SHOW : RES_IDLE;
        endcase
    end

    assign res_valid = (state_q == RES_SHOW);

    // Result sequencer: output registers, loaded on each lookup
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_hit       <= 1'b0;
            res_addr      <= '0;
            res_cmp_count <= '0;
        end else if (srch_en) begin
            res_hit       <= any_hit;
            res_addr      <= any_hit ? hit_addr : '0;
            res_cmp_count <= cmp_count;
        end
    end

    p_result_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en |=> res_valid);
    p_no_spurious_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> !res_valid);
    p_count_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(srch_en)) |-> (32'(res_cmp_count) <= $countones($past(live))));
    p_hit_needs_compare_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> (res_cmp_count != '0));
    p_miss_addr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_addr == '0));
endmodule

// File: tb/pcam_top_bench.sv
`timescale 1ns/1ps
module pcam_top_bench;
    localparam int WORDS = 8;
    localparam int WIDTH = 14;
    localparam int AW    = 3;
    localparam int CW    = 4;

    typedef struct packed {
        logic          hit;
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt_ones;
        logic [CW-1:0] cnt_bxor;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             inv_en = 1'b0;
    logic [AW-1:0]    inv_addr = '0;
    logic             srch_en = 1'b0;
    logic [WIDTH-1:0] srch_key = '0;

    logic             a_valid, a_hit, b_valid, b_hit;
    logic [AW-1:0]    a_addr, b_addr;
    logic [CW-1:0]    a_cnt, b_cnt;

    exp_t  sb_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;

    logic [WIDTH-1:0] m_data [WORDS];
    logic             m_live [WORDS];

    always #2.5 clk = ~clk;

    pcam_top #(.WORDS(WORDS), .WIDTH(WIDTH), .EXTRACT(pcam_pkg::EXT_ONES)) u_pcam_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .inv_en(inv_en), .inv_addr(inv_addr), .srch_en(srch_en), .srch_key(srch_key),
        .res_valid(a_valid), .res_hit(a_hit), .res_addr(a_addr), .res_cmp_count(a_cnt)
    );

    pcam_top #(.WORDS(WORDS), .WIDTH(WIDTH), .EXTRACT(pcam_pkg::EXT_BXOR)) u_pcam_top_bx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .inv_en(inv_en), .inv_addr(inv_addr), .srch_en(srch_en), .srch_key(srch_key),
        .res_valid(b_valid), .res_hit(b_hit), .res_addr(b_addr), .res_cmp_count(b_cnt)
    );

    // R1 signature: number of 1 bits
    function automatic logic [3:0] sig_ones(input logic [WIDTH-1:0] w);
        int c = 0;
        for (int i = 0; i < WIDTH; i++) c += int'(w[i]);
        return 4'(c);
    endfunction

    // R2 signature: XOR of 4-bit slices from bit 0, top slice zero-extended
    function automatic logic [3:0] sig_bxor(input logic [WIDTH-1:0] w);
        return w[3:0] ^ w[7:4] ^ w[11:8] ^ {2'b00, w[13:12]};
    endfunction

    function automatic exp_t model_lookup(input logic [WIDTH-1:0] k);
        exp_t e;
        int   c1 = 0;
        int   c2 = 0;
        e.hit  = 1'b0;
        e.addr = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (m_live[i]) begin
                if (sig_ones(m_data[i]) == sig_ones(k)) c1++;
                if (sig_bxor(m_data[i]) == sig_bxor(k)) c2++;
                if (!e.hit && m_data[i] == k) begin
                    e.hit  = 1'b1;
                    e.addr = AW'(i);
                end
            end
        end
        e.cnt_ones = CW'(c1);
        e.cnt_bxor = CW'(c2);
        return e;
    endfunction

    function automatic int live_count();
        int c = 0;
        for (int i = 0; i < WORDS; i++) c += int'(m_live[i]);
        return c;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [WIDTH-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        m_data[a] = d; m_live[a] = 1'b1;
    endtask

    task automatic do_inval(input int a);
        @(negedge clk);
        inv_en = 1'b1; inv_addr = AW'(a);
        @(posedge clk); #1;
        inv_en = 1'b0;
        m_live[a] = 1'b0;
    endtask

    task automatic do_search(input logic [WIDTH-1:0] k, input string req);
        @(negedge clk);
        sb_q.push_back(model_lookup(k));
        tag_q.push_back(req);
        srch_en = 1'b1; srch_key = k;
        @(posedge clk); #1;
        srch_en = 1'b0;
    endtask

    // R8: lookup in the write cycle sees the old contents
    task automatic do_write_search(input int a, input logic [WIDTH-1:0] d,
                                   input logic [WIDTH-1:0] k);
        @(negedge clk);
        sb_q.push_back(model_lookup(k));
        tag_q.push_back("R8");
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        srch_en = 1'b1; srch_key = k;
        @(posedge clk); #1;
        wr_en = 1'b0; srch_en = 1'b0;
        m_data[a] = d; m_live[a] = 1'b1;
    endtask

    // R3: write and invalidate of one entry in one cycle leaves it empty
    task automatic do_write_inval(input int a, input logic [WIDTH-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        inv_en = 1'b1; inv_addr = AW'(a);
        @(posedge clk); #1;
        wr_en = 1'b0; inv_en = 1'b0;
        m_data[a] = d; m_live[a] = 1'b0;
    endtask

    // Monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (rst_n && (a_valid || b_valid)) begin
            check("R8", "strobes agree", int'(b_valid), int'(a_valid));
            if (sb_q.size() == 0) begin
                check("R8", "unexpected result", 1, 0);
            end else begin
                exp_t  e;
                string t;
                e = sb_q.pop_front();
                t = tag_q.pop_front();
                check(t, "hit count", int'(a_hit), int'(e.hit));
                check(t, "hit slice", int'(b_hit), int'(e.hit));
                check(e.hit ? t : "R9", "addr count", int'(a_addr), int'(e.addr));
                check(e.hit ? t : "R9", "addr slice", int'(b_addr), int'(e.addr));
                check("R1", "compares count mode", int'(a_cnt), int'(e.cnt_ones));
                check("R2", "compares slice mode", int'(b_cnt), int'(e.cnt_bxor));
                check("R6", "count within live", int'(a_cnt <= CW'(WORDS)), 1);
            end
        end
    end

    initial begin : watchdog
        #(5 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] lfsr;
        for (int i = 0; i < WORDS; i++) begin
            m_data[i] = '0; m_live[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R4", "res_valid after reset", int'(a_valid), 0);
        check("R4", "res_hit after reset", int'(a_hit), 0);

        // R4 / R5: empty entries hold zero data but must not match key zero
        do_search(14'h0000, "R4");
        do_search(14'h3FFF, "R4");

        // R1 / R6: words sharing a ones count, distinct slice signatures
        do_write(0, 14'h0003);
        do_write(1, 14'h0005);
        do_write(2, 14'h3FFF);
        do_write(3, 14'h0000);
        do_search(14'h0005, "R7");
        do_search(14'h0006, "R6");     // same signature, no data match
        do_search(14'h3FFF, "R1");     // signature 14
        do_search(14'h0000, "R7");

        // R7: duplicate words, lowest address wins
        do_write(6, 14'h1234);
        do_write(4, 14'h1234);
        do_search(14'h1234, "R7");
        do_inval(4);
        do_search(14'h1234, "R5");
        do_inval(6);
        do_search(14'h1234, "R5");     // stale data in empty entries

        // R3: write plus invalidate of the same entry
        do_write_inval(5, 14'h0ABC);
        do_search(14'h0ABC, "R3");

        // R8: lookup alongside a write sees the old data
        do_write_search(7, 14'h2222, 14'h2222);
        do_search(14'h2222, "R3");

        // R8: idle gap shows no result
        repeat (2) @(negedge clk);
        check("R8", "no result when idle", int'(a_valid), 0);

        // Mixed traffic, back-to-back searches included
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            int op;
            int a;
            logic [WIDTH-1:0] d;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op = int'(lfsr[2:0]);
            a  = int'(lfsr[5:3]);
            d  = lfsr[15:2] & (lfsr[0] ? 14'h00FF : 14'h3FFF);
            if (op < 2) begin
                do_write(a, d);
            end else if (op == 2) begin
                do_inval(a);
            end else if (op < 6) begin
                do_search(m_data[a], "R7");
            end else begin
                do_search(d, "R6");
            end
            if (n % 50 == 0) check("R6", "model live bound", int'(live_count() <= WORDS), 1);
        end

        repeat (3) @(negedge clk);
        check("R8", "scoreboard drained", sb_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule